// File: doc/BRIEF.md
# JTAG Data Register Bank

This block holds the data-register half of a test access port. It has a one-bit bypass cell, a fixed identification register and a parameterised set of user data registers. The current instruction opcode picks exactly one of them as the serial path between TDI and TDO. A TAP state machine outside the block supplies the capture, shift and update strobes. The instruction register and the falling-edge retiming of TDO also sit outside.

Each user data register has two stages. A shift stage moves serial data one bit per rising TCK edge. A hold stage is the functional register the core logic sees. The core reads the hold stage in parallel and can also write it through its own write port, clocked on TCK. A JTAG update copies the shift stage into the hold stage, and a JTAG capture loads the hold stage's current value back into the shift stage, so a debug tool can both observe and control core state. If an opcode is not the identification opcode and not a user opcode, it falls back to the bypass cell.

Top module: `jtag_dr_bank`

## Requirements
- R1: While `rst_ni` is low, and after it rises, every user hold stage (`usr_q_o`) reads 0. With an unassigned opcode applied, `tdo_o` reads 0.
- R2: When bypass is selected, capture-DR loads the bypass bit with 0. During shift-DR, `tdo_o` then shows the `tdi_i` value sampled one rising edge earlier. An 8-bit scan input `d` therefore returns `{d[6:0],1'b0}`.
- R3: Every opcode other than `OP_ID` (default 4'h1) and `OP_USR_BASE+i` (defaults 4'h8, 4'h9) selects the bypass bit. A scan under such an opcode leaves every `usr_q_o` unchanged.
- R4: Under `OP_ID`, a capture followed by 32 shifts returns the identification code LSB first, and bit 0 of that code is 1. With the default parameter the code is 32'h1A5C3E17.
- R5: Under `OP_USR_BASE+i`, data shifts LSB first from `tdi_i` toward `tdo_o`. After `USR_W` shifts and an update, `usr_q_o[i]` equals the shifted-in word. The bits that come out are the hold value loaded at capture.
- R6: Capture-DR and shift-DR never change any `usr_q_o`. Only update-DR, or a functional write, changes a hold stage.
- R7: An update-DR changes only the user register selected by the opcode. All other user hold stages keep their value.
- R8: With `usr_we_i[i]` high at a rising TCK edge, and no JTAG update of register i on that edge, `usr_q_o[i]` takes `usr_wd_i[i]`. A later capture returns that value on the serial path.
- R9: When a JTAG update of register i and `usr_we_i[i]` fall on the same edge, `usr_q_o[i]` takes the shifted-in value and the functional write is dropped.
- R10: Driving `rst_ni` low clears every hold stage at once, without waiting for a TCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock, rising edge active |
| rst_ni | input | 1 | Asynchronous test reset, active low |
| tdi_i | input | 1 | Serial data in |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| ir_opcode_i | input | IR_W | Current instruction opcode |
| usr_we_i | input | N_USR | Functional write enable, one per user register |
| usr_wd_i | input | N_USR x USR_W | Functional write data |
| usr_q_o | output | N_USR x USR_W | Hold stage value seen by core logic |
| tdo_o | output | 1 | Serial data out of the selected register |

## Verification
The bench sweeps all sixteen opcodes. This catches a decoder that sends an unassigned code to a user register or to the identification register: such a design would return stale data instead of the one-bit-delayed input, and might corrupt a hold value. All 256 values are written to one user register and read back on the next capture. This exposes a reversed shift direction, which would return bit-mirrored words, and a register that is off by one bit, which would return shifted words. The hold values are also sampled in the middle of a shift and checked against the values before it, to catch a design that leaks shift data early. A functional write is placed on the same edge as an update, to expose the wrong priority. The reset is pulsed between clock edges, to expose a synchronous reset.

// File: rtl/jtag_dr_pkg.sv
package jtag_dr_pkg;
  typedef enum logic [1:0] {
    SEL_BYP = 2'd0,
    SEL_ID  = 2'd1,
    SEL_USR = 2'd2
  } dr_kind_e;
endpackage

// File: rtl/jtag_dr_decode.sv
module jtag_dr_decode
  import jtag_dr_pkg::*;
#(
  parameter int IR_W        = 4,
  parameter int N_USR       = 2,
  parameter int OP_ID       = 1,
  parameter int OP_USR_BASE = 8
) (
  input  logic [IR_W-1:0]  opcode_i,
  output dr_kind_e         kind_o,
  output logic [N_USR-1:0] usr_sel_o
);
  logic [N_USR-1:0] hit;

  for (genvar g = 0; g < N_USR; g++) begin : g_hit
    assign hit[g] = (opcode_i == IR_W'(OP_USR_BASE + g));
  end

  // id opcode outranks a colliding user opcode; all else falls to bypass
  always_comb begin
    if (opcode_i == IR_W'(OP_ID))  kind_o = SEL_ID;
    else if (|hit)                 kind_o = SEL_USR;
    else                           kind_o = SEL_BYP;
    usr_sel_o = (kind_o == SEL_USR) ? hit : '0;
  end
endmodule

// File: rtl/jtag_dr_bypass.sv
module jtag_dr_bypass (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic tdi_i,
  output logic so_o
);
  logic bp_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                bp_q <= 1'b0;
    else if (sel_i && capture_i) bp_q <= 1'b0;
    else if (sel_i && shift_i)   bp_q <= tdi_i;
  end

  assign so_o = bp_q;
endmodule

// File: rtl/jtag_dr_id.sv
module jtag_dr_id #(
  parameter int          ID_W   = 32,
  parameter logic [31:0] ID_VAL = 32'h1A5C_3E17
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic tdi_i,
  output logic so_o
);
  localparam logic [ID_W-1:0] CODE = {ID_VAL[ID_W-1:1], 1'b1};

  logic [ID_W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                 sr_q <= '0;
    else if (sel_i && capture_i) sr_q <= CODE;
    else if (sel_i && shift_i)   sr_q <= {tdi_i, sr_q[ID_W-1:1]};
  end

  assign so_o = sr_q[0];
endmodule

// File: rtl/jtag_dr_user.sv
module jtag_dr_user #(
  parameter int W = 8
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         update_i,
  input  logic         tdi_i,
  input  logic         fwe_i,
  input  logic [W-1:0] fwd_i,
  output logic [W-1:0] q_o,
  output logic         so_o
);
  logic [W-1:0] sr_q, hold_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                 sr_q <= '0;
    else if (sel_i && capture_i) sr_q <= hold_q;
    else if (sel_i && shift_i)   sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  // jtag update beats the functional write port
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                hold_q <= '0;
    else if (sel_i && update_i) hold_q <= sr_q;
    else if (fwe_i)             hold_q <= fwd_i;
  end

  assign q_o  = hold_q;
  assign so_o = sr_q[0];
endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank
  import jtag_dr_pkg::*;
#(
  parameter int          IR_W        = 4,
  parameter int          N_USR       = 2,
  parameter int          USR_W       = 8,
  parameter int          OP_ID       = 1,
  parameter int          OP_USR_BASE = 8,
  parameter logic [31:0] ID_VAL      = 32'h1A5C_3E17
) (
  input  logic                        tck_i,
  input  logic                        rst_ni,
  input  logic                        tdi_i,
  input  logic                        capture_dr_i,
  input  logic                        shift_dr_i,
  input  logic                        update_dr_i,
  input  logic [IR_W-1:0]             ir_opcode_i,
  input  logic [N_USR-1:0]            usr_we_i,
  input  logic [N_USR-1:0][USR_W-1:0] usr_wd_i,
  output logic [N_USR-1:0][USR_W-1:0] usr_q_o,
  output logic                        tdo_o
);
  dr_kind_e         kind;
  logic [N_USR-1:0] usr_sel;
  logic [N_USR-1:0] usr_so;
  logic             byp_so, id_so;
  logic             usr_tdo;

  jtag_dr_decode #(
    .IR_W(IR_W), .N_USR(N_USR), .OP_ID(OP_ID), .OP_USR_BASE(OP_USR_BASE)
  ) u_dec (
    .opcode_i (ir_opcode_i),
    .kind_o   (kind),
    .usr_sel_o(usr_sel)
  );

  jtag_dr_bypass u_byp (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .sel_i    (kind == SEL_BYP),
    .capture_i(capture_dr_i),
    .shift_i  (shift_dr_i),
    .tdi_i    (tdi_i),
    .so_o     (byp_so)
  );

  jtag_dr_id #(.ID_W(32), .ID_VAL(ID_VAL)) u_id (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .sel_i    (kind == SEL_ID),
    .capture_i(capture_dr_i),
    .shift_i  (shift_dr_i),
    .tdi_i    (tdi_i),
    .so_o     (id_so)
  );

  for (genvar g = 0; g < N_USR; g++) begin : g_usr
    jtag_dr_user #(.W(USR_W)) u_usr (
      .tck_i    (tck_i),
      .rst_ni   (rst_ni),
      .sel_i    (usr_sel[g]),
      .capture_i(capture_dr_i),
      .shift_i  (shift_dr_i),
      .update_i (update_dr_i),
      .tdi_i    (tdi_i),
      .fwe_i    (usr_we_i[g]),
      .fwd_i    (usr_wd_i[g]),
      .q_o      (usr_q_o[g]),
      .so_o     (usr_so[g])
    );
  end

  assign usr_tdo = |(usr_so & usr_sel);

  always_comb begin
    unique case (kind)
      SEL_ID:  tdo_o = id_so;
      SEL_USR: tdo_o = usr_tdo;
      default: tdo_o = byp_so;
    endcase
  end
endmodule

// File: rtl/jtag_dr_bank_chk.sv
module jtag_dr_bank_chk #(
  parameter int IR_W        = 4,
  parameter int N_USR       = 2,
  parameter int USR_W       = 8,
  parameter int OP_ID       = 1,
  parameter int OP_USR_BASE = 8
) (
  input logic                        tck_i,
  input logic                        rst_ni,
  input logic                        tdi_i,
  input logic                        capture_dr_i,
  input logic                        shift_dr_i,
  input logic                        update_dr_i,
  input logic [IR_W-1:0]             ir_opcode_i,
  input logic [N_USR-1:0]            usr_we_i,
  input logic [N_USR-1:0][USR_W-1:0] usr_wd_i,
  input logic [N_USR-1:0][USR_W-1:0] usr_q_o,
  input logic                        tdo_o
);
  logic assigned;

  always_comb begin
    assigned = (ir_opcode_i == IR_W'(OP_ID));
    for (int i = 0; i < N_USR; i++)
      if (ir_opcode_i == IR_W'(OP_USR_BASE + i)) assigned = 1'b1;
  end

  assert_byp_capture_R2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (capture_dr_i && !assigned) |=> (!$stable(ir_opcode_i) || tdo_o == 1'b0));

  assert_unassigned_delay_R3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_dr_i && !assigned) |=> (!$stable(ir_opcode_i) || tdo_o == $past(tdi_i)));

  assert_id_lsb_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (capture_dr_i && ir_opcode_i == IR_W'(OP_ID)) |=> (!$stable(ir_opcode_i) || tdo_o));

  assert_hold_stable_R6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!update_dr_i && usr_we_i == '0) |=> $stable(usr_q_o));

  for (genvar g = 0; g < N_USR; g++) begin : g_chk
    assert_unsel_keep_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
      (update_dr_i && ir_opcode_i != IR_W'(OP_USR_BASE + g) && !usr_we_i[g])
      |=> $stable(usr_q_o[g]));

    assert_func_write_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
      (usr_we_i[g] && !(update_dr_i && ir_opcode_i == IR_W'(OP_USR_BASE + g)))
      |=> usr_q_o[g] == $past(usr_wd_i[g]));
  end
endmodule

bind jtag_dr_bank jtag_dr_bank_chk #(
  .IR_W(IR_W), .N_USR(N_USR), .USR_W(USR_W), .OP_ID(OP_ID), .OP_USR_BASE(OP_USR_BASE)
) u_chk (
  .tck_i(tck_i), .rst_ni(rst_ni), .tdi_i(tdi_i), .capture_dr_i(capture_dr_i),
  .shift_dr_i(shift_dr_i), .update_dr_i(update_dr_i), .ir_opcode_i(ir_opcode_i),
  .usr_we_i(usr_we_i), .usr_wd_i(usr_wd_i), .usr_q_o(usr_q_o), .tdo_o(tdo_o)
);

// File: tb/sim_jtag_dr_bank.sv
`timescale 1ns/1ps
module sim_jtag_dr_bank;
  localparam int          IR_W  = 4;
  localparam int          N_USR = 2;
  localparam int          USR_W = 8;
  localparam logic [31:0] IDV   = 32'h1A5C_3E17;

  logic                        clk = 1'b0;
  logic                        rst_n = 1'b0;
  logic                        tdi = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0;
  logic [IR_W-1:0]             op = 4'hF;
  logic [N_USR-1:0]            we = '0;
  logic [N_USR-1:0][USR_W-1:0] wd = '0;
  logic [N_USR-1:0][USR_W-1:0] q;
  logic                        tdo;

  int  total = 0, failed = 0;
  bit  done = 0;
  logic [N_USR-1:0][USR_W-1:0] mid_q;

  always #2.5 clk = ~clk;

  jtag_dr_bank #(.IR_W(IR_W), .N_USR(N_USR), .USR_W(USR_W), .ID_VAL(IDV)) u0 (
    .tck_i(clk), .rst_ni(rst_n), .tdi_i(tdi), .capture_dr_i(cap), .shift_dr_i(sh),
    .update_dr_i(upd), .ir_opcode_i(op), .usr_we_i(we), .usr_wd_i(wd),
    .usr_q_o(q), .tdo_o(tdo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // capture, n shifts, update; optional functional write on the update edge
  task automatic scan(input logic [IR_W-1:0] o, input logic [31:0] din, input int n,
                      input logic [N_USR-1:0] cwe, input logic [USR_W-1:0] cwd,
                      output logic [31:0] dout);
    dout = '0;
    @(negedge clk); op = o; cap = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cap = 1'b0; sh = 1'b1; tdi = din[i];
      #1 dout[i] = tdo;
    end
    @(negedge clk); sh = 1'b0; #1 mid_q = q;
    upd = 1'b1; we = cwe; wd = {N_USR{cwd}};
    @(negedge clk); upd = 1'b0; we = '0;
  endtask

  initial begin
    logic [31:0] r;
    logic [N_USR-1:0][USR_W-1:0] pre;
    logic [USR_W-1:0] prev;
    #1 chk("R1 hold in reset", 32'(q), 32'h0);
    #10 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 hold after reset", 32'(q), 32'h0);
    chk("R1 tdo after reset", 32'(tdo), 32'h0);

    scan(4'h1, 32'h0, 32, '0, '0, r);
    chk("R4 id code", r, IDV | 32'h1);
    chk("R4 id lsb", 32'(r[0]), 32'h1);

    for (int o = 0; o < 16; o++) begin
      if (o == 1 || o == 8 || o == 9) continue;
      pre = q;
      scan(4'(o), 32'(8'h5B ^ o), 8, '0, '0, r);
      chk($sformatf("R2 R3 bypass op %0d", o), r & 32'hFF,
          32'({8'h5B ^ 8'(o)} << 1) & 32'hFF);
      chk($sformatf("R3 no effect op %0d", o), 32'(q), 32'(pre));
    end

    scan(4'h8, 32'hA5, 8, '0, '0, r);
    chk("R5 usr0 write", 32'(q[0]), 32'hA5);
    chk("R7 usr1 untouched", 32'(q[1]), 32'h0);
    scan(4'h8, 32'h3C, 8, '0, '0, r);
    chk("R5 usr0 capture", r & 32'hFF, 32'hA5);
    chk("R6 hold during shift", 32'(mid_q[0]), 32'hA5);
    chk("R5 usr0 second write", 32'(q[0]), 32'h3C);

    prev = 8'h0;
    for (int v = 0; v < 256; v++) begin
      pre = q;
      scan(4'h9, 32'(v), 8, '0, '0, r);
      chk($sformatf("R5 usr1 readback %0d", v), r & 32'hFF, 32'(prev));
      chk($sformatf("R6 usr1 mid shift %0d", v), 32'(mid_q), 32'(pre));
      chk($sformatf("R5 usr1 write %0d", v), 32'(q[1]), 32'(v));
      chk($sformatf("R7 usr0 kept %0d", v), 32'(q[0]), 32'h3C);
      prev = 8'(v);
    end

    @(negedge clk); we = 2'b01; wd = {8'h00, 8'h5A};
    @(negedge clk); we = '0;
    chk("R8 functional write", 32'(q[0]), 32'h5A);
    chk("R8 other kept", 32'(q[1]), 32'hFF);
    scan(4'h8, 32'h77, 8, '0, '0, r);
    chk("R8 captured func value", r & 32'hFF, 32'h5A);

    scan(4'h9, 32'h11, 8, 2'b10, 8'hEE, r);
    chk("R9 jtag wins", 32'(q[1]), 32'h11);
    scan(4'h9, 32'h22, 8, 2'b01, 8'hC3, r);
    chk("R9 func write other reg", 32'(q[0]), 32'hC3);
    chk("R9 update reg", 32'(q[1]), 32'h22);

    @(negedge clk); #1 rst_n = 1'b0;
    #0.5 chk("R10 async clear", 32'(q), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule